// File: doc/BRIEF.md
# Chip-Select Gated Registered Command Buffer

This block is the register stage that sits between a memory controller and a rank of DRAM devices on a registered module. On every rising clock edge it captures a 28-bit address/command word and two active-low chip-select lines. It then drives every captured bit out on two identical copies, named A and B, so that each copy can feed half of the module's loads.

To save power while the rank is idle, a gate-enable input can freeze the bulk of the register. When gate-enable is high and both chip selects are high, the gated bits keep their last value and their outputs do not toggle. A small group of per-rank control bits (two clock-enable and two termination-control bits) and the chip-select pass-through keep updating on every edge. Where those four control bits sit in the input word depends on a static mapping input, which picks one of two pin arrangements.

An asynchronous active-low reset clears every register at once and takes priority over the gating. The parity check that normally accompanies this register is a separate block.

Top module: `cs_gated_cmd_buffer`

## Requirements
- R1: Outputs change only on a rising clock edge. An input change between edges leaves every output unchanged, and `q_a` always equals `q_b` and `qcs_a` always equals `qcs_b`.
- R2: While `rst_n` is low, every output reads zero. Zero appears as soon as `rst_n` falls, without waiting for a clock edge, and stays zero across clock edges for as long as `rst_n` is low.
- R3: On an edge where `gate_en` = 1 and `cs_n` = 2'b11, every bit outside the live group keeps its previous value.
- R4: On an edge where `gate_en` = 0, or either `cs_n` bit is 0, every bit of `q_a`/`q_b` takes the value `d_in` had at that edge.
- R5: The four bits of the live group load `d_in` on every edge, whatever the values of `gate_en` and `cs_n`.
- R6: `qcs_a` and `qcs_b` take the value `cs_n` had at each edge, and the gating never freezes them.
- R7: With `map_b` = 0, the live group is bit positions 12, 13, 14 and 15 (zero-based) of `d_in`. With `map_b` = 1, it is bit positions 15, 17, 19 and 21. `map_b` is changed only while `rst_n` is low.
- R8: On the first edge after `rst_n` rises, the register loads the inputs sampled at that edge, subject to the gating of R3 to R5. Bits held by the gating stay at zero.
- R9: Reset overrides the gating: driving `rst_n` low while the register is frozen still clears all outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_b | input | 1 | Static mapping select: 0 selects arrangement A, 1 selects arrangement B |
| gate_en | input | 1 | Enables freezing of the gated bits while both chip selects are high |
| cs_n | input | 2 | Active-low chip selects, one per rank |
| d_in | input | 28 | Address/command word |
| q_a | output | 28 | Registered word, copy A |
| q_b | output | 28 | Registered word, copy B |
| qcs_a | output | 2 | Registered chip selects, copy A |
| qcs_b | output | 2 | Registered chip selects, copy B |

## Verification
The bench builds the block with its default parameters: a 28-bit word, two chip selects and the two default live-group masks. In each mapping, it sweeps all eight combinations of `gate_en` and `cs_n` across several consecutive cycles with changing data words. This brings within reach every gating decision and every hold run, including runs where a frozen bit's input differs from its held value. Resets are applied both mid-cycle and while the register is frozen. The first edge after each release is checked under both a frozen and a loading pattern.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    localparam int DEF_DATA_W = 28;
    localparam int DEF_NUM_CS = 2;

    // Live (never frozen) group for each pin arrangement.
    localparam logic [DEF_DATA_W-1:0] DEF_LIVE_MASK_A = 28'h000F000; // bits 12..15
    localparam logic [DEF_DATA_W-1:0] DEF_LIVE_MASK_B = 28'h02A8000; // bits 15,17,19,21

    typedef enum logic {
        MAP_A = 1'b0,
        MAP_B = 1'b1
    } map_mode_e;

    typedef struct packed {
        logic hold;        // gated bits keep their value this edge
        logic load_gated;  // gated bits take their input this edge
    } gate_ctl_t;

    function automatic map_mode_e decode_map(input logic map_b);
        return map_b ? MAP_B : MAP_A;
    endfunction

    function automatic gate_ctl_t make_gate_ctl(input logic gate_en,
                                                input logic all_idle);
        gate_ctl_t c;
        c.hold       = gate_en & all_idle;
        c.load_gated = ~c.hold;
        return c;
    endfunction

endpackage

// File: rtl/cmdbuf_map_sel.sv
module cmdbuf_map_sel
    import cmdbuf_pkg::*;
#(
    parameter int                DATA_W      = DEF_DATA_W,
    parameter logic [DATA_W-1:0] LIVE_MASK_A = DEF_LIVE_MASK_A,
    parameter logic [DATA_W-1:0] LIVE_MASK_B = DEF_LIVE_MASK_B
) (
    input  logic              map_b,
    output map_mode_e         mode,
    output logic [DATA_W-1:0] live_mask
);

    always_comb begin
        mode = decode_map(map_b);
        unique case (mode)
            MAP_A:   live_mask = LIVE_MASK_A;
            MAP_B:   live_mask = LIVE_MASK_B;
            default: live_mask = LIVE_MASK_A;
        endcase
    end

endmodule

// File: rtl/cmdbuf_gate_ctl.sv
module cmdbuf_gate_ctl
    import cmdbuf_pkg::*;
#(
    parameter int NUM_CS = DEF_NUM_CS
) (
    input  logic              gate_en,
    input  logic [NUM_CS-1:0] cs_n,
    output gate_ctl_t         ctl
);

    logic all_idle;

    always_comb begin
        all_idle = &cs_n;
        ctl      = make_gate_ctl(gate_en, all_idle);
    end

endmodule

// File: rtl/cmdbuf_bit_reg.sv
module cmdbuf_bit_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic load_gated,
    input  logic d,
    output logic q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (live || load_gated) begin
            q <= d;
        end
    end

endmodule

// File: rtl/cmdbuf_cs_reg.sv
module cmdbuf_cs_reg
    import cmdbuf_pkg::*;
#(
    parameter int NUM_CS = DEF_NUM_CS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CS-1:0] cs_n,
    output logic [NUM_CS-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= cs_n;
        end
    end

endmodule

// File: rtl/cs_gated_cmd_buffer.sv
module cs_gated_cmd_buffer
    import cmdbuf_pkg::*;
#(
    parameter int                DATA_W      = DEF_DATA_W,
    parameter int                NUM_CS      = DEF_NUM_CS,
    parameter logic [DATA_W-1:0] LIVE_MASK_A = DEF_LIVE_MASK_A,
    parameter logic [DATA_W-1:0] LIVE_MASK_B = DEF_LIVE_MASK_B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_b,
    input  logic              gate_en,
    input  logic [NUM_CS-1:0] cs_n,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] q_a,
    output logic [DATA_W-1:0] q_b,
    output logic [NUM_CS-1:0] qcs_a,
    output logic [NUM_CS-1:0] qcs_b
);

    localparam int NUM_COPIES = 2;

    map_mode_e         mode;
    logic [DATA_W-1:0] live_mask;
    gate_ctl_t         ctl;
    logic [DATA_W-1:0] q_reg;
    logic [NUM_CS-1:0] cs_q;

    cmdbuf_map_sel #(
        .DATA_W      (DATA_W),
        .LIVE_MASK_A (LIVE_MASK_A),
        .LIVE_MASK_B (LIVE_MASK_B)
    ) u_map (
        .map_b     (map_b),
        .mode      (mode),
        .live_mask (live_mask)
    );

    cmdbuf_gate_ctl #(
        .NUM_CS (NUM_CS)
    ) u_gate (
        .gate_en (gate_en),
        .cs_n    (cs_n),
        .ctl     (ctl)
    );

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            cmdbuf_bit_reg u_bit (
                .clk        (clk),
                .rst_n      (rst_n),
                .live       (live_mask[i]),
                .load_gated (ctl.load_gated),
                .d          (d_in[i]),
                .q          (q_reg[i])
            );
        end
    endgenerate

    cmdbuf_cs_reg #(
        .NUM_CS (NUM_CS)
    ) u_cs (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .q     (cs_q)
    );

    // Output fan-out: each copy is driven from the single register.
    logic [NUM_COPIES-1:0][DATA_W-1:0] q_copy;
    logic [NUM_COPIES-1:0][NUM_CS-1:0] cs_copy;

    generate
        for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
            assign q_copy[c]  = q_reg;
            assign cs_copy[c] = cs_q;
        end
    endgenerate

    assign q_a   = q_copy[0];
    assign q_b   = q_copy[1];
    assign qcs_a = cs_copy[0];
    assign qcs_b = cs_copy[1];

    // R3: gated bits stay frozen across an edge with gating active
    a_r3_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && (&cs_n)) |=> $stable(q_a & ~live_mask));

    // R4: any active chip select or gate disabled loads the whole word
    a_r4_full_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en || !(&cs_n)) |=> (q_b == $past(d_in)));

    // R5: live group follows its inputs on every edge
    a_r5_live_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q_a & live_mask) == ($past(d_in) & live_mask)));

    // R6: chip-select pass-through never freezes
    a_r6_cs_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (qcs_b == $past(cs_n)));

endmodule

// File: tb/cs_gated_cmd_buffer_tb.sv
module cs_gated_cmd_buffer_tb;
    import cmdbuf_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DW = DEF_DATA_W;
    localparam int CW = DEF_NUM_CS;
    localparam logic [DW-1:0] MASK_A = 28'h000F000;
    localparam logic [DW-1:0] MASK_B = 28'h02A8000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          map_b = 1'b0;
    logic          gate_en = 1'b0;
    logic [CW-1:0] cs_n = '1;
    logic [DW-1:0] d_in = '0;
    logic [DW-1:0] q_a, q_b;
    logic [CW-1:0] qcs_a, qcs_b;

    int n_checks = 0;
    int n_fail = 0;

    logic [DW-1:0] exp_q = '0;
    logic [CW-1:0] exp_cs = '0;
    bit            first_after_rst = 1'b0;

    cs_gated_cmd_buffer u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .map_b   (map_b),
        .gate_en (gate_en),
        .cs_n    (cs_n),
        .d_in    (d_in),
        .q_a     (q_a),
        .q_b     (q_b),
        .qcs_a   (qcs_a),
        .qcs_b   (qcs_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int n);
        logic [31:0] v;
        v = (n * 32'h9E3779B1) ^ (n << 7) ^ 32'h05A5A5A5;
        return v[DW-1:0];
    endfunction

    // Called at a falling edge; leaves the bench at the next falling edge.
    task automatic step(input logic [DW-1:0] d, input logic ge, input logic [CW-1:0] cs);
        logic [DW-1:0] mask;
        bit            hold;
        d_in = d; gate_en = ge; cs_n = cs;
        #1;
        chk("R1 no change between edges", 32'(q_a), 32'(exp_q));
        @(negedge clk);
        mask = map_b ? MASK_B : MASK_A;
        hold = ge && (cs == 2'b11);
        exp_q = hold ? ((exp_q & ~mask) | (d & mask)) : d;
        exp_cs = cs;
        if (first_after_rst) begin
            chk("R8 first edge after reset", 32'(q_a), 32'(exp_q));
            first_after_rst = 1'b0;
        end
        if (hold)
            chk("R3 gated bits held", 32'(q_a & ~mask), 32'(exp_q & ~mask));
        else
            chk("R4 full load", 32'(q_a & ~mask), 32'(exp_q & ~mask));
        chk("R5 R7 live group follows", 32'(q_a & mask), 32'(exp_q & mask));
        chk("R1 copy B matches", 32'(q_b), 32'(exp_q));
        chk("R6 cs pass-through A", 32'(qcs_a), 32'(exp_cs));
        chk("R6 cs pass-through B", 32'(qcs_b), 32'(exp_cs));
    endtask

    // Called at a falling edge; asserts reset a quarter period later.
    task automatic pulse_reset(input string req, input logic new_map);
        #(CLK_PERIOD/4);
        rst_n = 1'b0;
        #1;
        chk({req, " immediate clear q_a"}, 32'(q_a), 32'h0);
        chk({req, " immediate clear qcs"}, 32'({qcs_a, qcs_b}), 32'h0);
        map_b = new_map;
        d_in = '1; gate_en = 1'b0; cs_n = 2'b00;
        @(negedge clk);
        chk("R2 held clear across edge", 32'(q_b), 32'h0);
        rst_n = 1'b1;
        exp_q = '0; exp_cs = '0;
        first_after_rst = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk("R2 reset state q_a", 32'(q_a), 32'h0);
        chk("R2 reset state qcs_a", 32'(qcs_a), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        first_after_rst = 1'b1;

        for (int m = 0; m < 2; m++) begin
            if (m == 1) pulse_reset("R2", 1'b1);
            // first edge after release: frozen pattern, gated bits stay zero
            step(pat(1000 + m), 1'b1, 2'b11);
            for (int combo = 0; combo < 8; combo++) begin
                for (int k = 0; k < 4; k++)
                    step(pat(m * 64 + combo * 4 + k), combo[2], combo[1:0]);
            end
            // long frozen run with extreme patterns
            step('1, 1'b0, 2'b10);
            step('0, 1'b1, 2'b11);
            step('1, 1'b1, 2'b11);
            step(28'h5555555, 1'b1, 2'b11);
            step(28'hAAAAAAA, 1'b0, 2'b11);
        end

        // reset while frozen (priority over gating)
        step(28'hFFFFFFF, 1'b0, 2'b11);
        step(28'h1234567, 1'b1, 2'b11);
        pulse_reset("R9", 1'b0);
        // first edge after release while loading
        step(28'hC3C3C3C, 1'b0, 2'b01);
        step(28'h0F0F0F0, 1'b1, 2'b11);
        step(28'hF0F0F0F, 1'b1, 2'b11);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule